// File: doc/BRIEF.md
# Per-Window Colour Lookup Chain

This block holds a window's three colour tables, one each for red, green and blue. Each table has 2^CH_W entries of CH_W bits and is followed by a second set of three tables that stand for the shared framebuffer stage. It runs in one of two modes, chosen per pixel:

- **True-colour mode.** Each incoming channel value, taken after colour conversion, indexes its own table. This is how gamma correction is done.
- **Palette mode.** A pixel index of PAL_W bits, zero-extended, indexes all three tables, so the tables act as the palette.

By default the window result then goes through the shared tables, so two lookups are applied in series. A per-window override flag makes the shared stage pass the window result through unchanged.

Both table sets are loaded through one update port:

- An update command gives a target (window or shared), a start index, an entry count and, for window updates, the override flag.
- Data beats then follow, one entry per beat, written to ascending indices.
- Each beat carries a 16-bit word per channel that repeats the 8-bit value in both bytes. Only the upper byte is kept.
- A count of zero changes only the flag.
- Beats that would run past the last index are dropped.

Top module: `rgb_lut_chain`

## Requirements
- R1: After reset, out_valid is low, the override flag is clear (so both lookups apply), and no update beats are pending.
- R2: In true-colour mode (px_palette=0) with the override clear, out_r = S_r[W_r[px_r]], and likewise for green with S_g/W_g and blue with S_b/W_b. Here W is a window table and S is a shared table.
- R3: In palette mode (px_palette=1), all three window tables are indexed by px_index zero-extended to CH_W bits, and the results then pass through the shared stage.
- R4: The override flag is upd_bypass, sampled on an upd_go whose upd_global is 0. While it is set, outputs equal the window lookup alone. An upd_go with upd_global=1 leaves the flag unchanged.
- R5: upd_go loads the entry count from upd_len and the first index from upd_start. Each following upd_wr beat writes the next ascending entry of the selected table set, storing bits [2*CH_W-1:CH_W] of upd_r, upd_g and upd_b.
- R6: An upd_go with upd_len=0 updates only the flag. Later upd_wr beats change no entry.
- R7: Beats addressed past index 2^CH_W-1 are dropped and do not wrap to entry 0. They still consume the count.
- R8: Once upd_len beats have been accepted, further upd_wr beats change no entry.
- R9: out_valid follows px_valid exactly two clock cycles later, and the output colour belongs to that pixel.
- R10: A beat that writes a window entry in the same cycle that a pixel reads that entry gives the pixel the old value. The next pixel sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_go | input | 1 | Starts an update command |
| upd_global | input | 1 | Update target: 1 = shared tables, 0 = window tables |
| upd_start | input | CH_W | First entry index |
| upd_len | input | CH_W+1 | Number of entries to write |
| upd_bypass | input | 1 | Override flag value (window target only) |
| upd_wr | input | 1 | Data beat strobe |
| upd_r | input | 2*CH_W | Red entry word, value in upper byte |
| upd_g | input | 2*CH_W | Green entry word, value in upper byte |
| upd_b | input | 2*CH_W | Blue entry word, value in upper byte |
| px_valid | input | 1 | Pixel strobe |
| px_palette | input | 1 | 1 = palette mode, 0 = true-colour mode |
| px_index | input | PAL_W | Palette index |
| px_r | input | CH_W | Red channel in |
| px_g | input | CH_W | Green channel in |
| px_b | input | CH_W | Blue channel in |
| out_valid | output | 1 | Output strobe |
| out_r | output | CH_W | Red out |
| out_g | output | CH_W | Green out |
| out_b | output | CH_W | Blue out |

## Verification
The bench builds the block with CH_W=8 and PAL_W=6. With these values a narrow palette index reaches only entries 0 to 63 through zero-extension, while true-colour lookups cover all 256 entries. The 8-bit channel width lets a load starting at index 254 run into the top of the table, which exposes the truncation rule. Both table sets are fully loaded with distinct functions, so any index swap or missed stage shows up as a wrong colour.

// File: rtl/rgb_lut_chain.sv
module rgb_lut_chain #(
  parameter int CH_W  = 8,
  parameter int PAL_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_go,
  input  logic                upd_global,
  input  logic [CH_W-1:0]     upd_start,
  input  logic [CH_W:0]       upd_len,
  input  logic                upd_bypass,
  input  logic                upd_wr,
  input  logic [2*CH_W-1:0]   upd_r,
  input  logic [2*CH_W-1:0]   upd_g,
  input  logic [2*CH_W-1:0]   upd_b,
  input  logic                px_valid,
  input  logic                px_palette,
  input  logic [PAL_W-1:0]    px_index,
  input  logic [CH_W-1:0]     px_r,
  input  logic [CH_W-1:0]     px_g,
  input  logic [CH_W-1:0]     px_b,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_r,
  output logic [CH_W-1:0]     out_g,
  output logic [CH_W-1:0]     out_b
);
  localparam int DEPTH  = 1 << CH_W;
  localparam int WORD_W = 2 * CH_W;
  localparam int CNT_W  = CH_W + 1;

  logic [CNT_W-1:0] cursor, left;
  logic             tgt_global, bypass, s1_valid;

  wire wr_fire  = upd_wr && !upd_go && (left != '0);
  wire in_range = !cursor[CH_W];
  wire [CH_W-1:0] wr_idx = cursor[CH_W-1:0];
  wire [CH_W-1:0] pal_idx = CH_W'(px_index);

  wire [WORD_W-1:0] wdata [3];
  wire [CH_W-1:0]   pdata [3];
  assign wdata[0] = upd_r;
  assign wdata[1] = upd_g;
  assign wdata[2] = upd_b;
  assign pdata[0] = px_r;
  assign pdata[1] = px_g;
  assign pdata[2] = px_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor     <= '0;
      left       <= '0;
      tgt_global <= 1'b0;
      bypass     <= 1'b0;
      s1_valid   <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      s1_valid  <= px_valid;
      out_valid <= s1_valid;
      if (upd_go) begin
        cursor     <= {1'b0, upd_start};
        left       <= upd_len;
        tgt_global <= upd_global;
        if (!upd_global) bypass <= upd_bypass;
      end else if (wr_fire) begin
        cursor <= cursor + 1'b1;
        left   <= left - 1'b1;
      end
    end
  end

  for (genvar c = 0; c < 3; c++) begin : lane
    logic [CH_W-1:0] win_tab [DEPTH];
    logic [CH_W-1:0] shr_tab [DEPTH];
    logic [CH_W-1:0] s1_q, o_q;
    wire  [CH_W-1:0] rd_idx = px_palette ? pal_idx : pdata[c];

    always_ff @(posedge clk) begin
      if (wr_fire && in_range && !tgt_global)
        win_tab[wr_idx] <= wdata[c][WORD_W-1:CH_W];
      if (px_valid)
        s1_q <= win_tab[rd_idx];
    end

    always_ff @(posedge clk) begin
      if (wr_fire && in_range && tgt_global)
        shr_tab[wr_idx] <= wdata[c][WORD_W-1:CH_W];
      if (s1_valid)
        o_q <= bypass ? s1_q : shr_tab[s1_q];
    end
  end

  assign out_r = lane[0].o_q;
  assign out_g = lane[1].o_q;
  assign out_b = lane[2].o_q;
endmodule

module rgb_lut_chain_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_go,
  input logic             upd_global,
  input logic             upd_bypass,
  input logic             upd_wr,
  input logic [CNT_W-1:0] upd_len,
  input logic [CNT_W-1:0] left,
  input logic             bypass,
  input logic             s1_valid,
  input logic             out_valid
);
  a_r1_len_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |=> left == $past(upd_len));
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_wr && !upd_go && left != '0) |=> left == $past(left) - 1'b1);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_go && left == '0) |=> left == '0);
  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_go && !upd_global) |=> $stable(bypass));
  a_r4_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && !upd_global) |=> bypass == $past(upd_bypass));
  a_r9_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  a_r9_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
endmodule

bind rgb_lut_chain rgb_lut_chain_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_go(upd_go), .upd_global(upd_global),
  .upd_bypass(upd_bypass), .upd_wr(upd_wr), .upd_len(upd_len), .left(left),
  .bypass(bypass), .s1_valid(s1_valid), .out_valid(out_valid)
);

// File: tb/rgb_lut_chain_test.sv
module rgb_lut_chain_test;
  localparam int CH_W = 8;
  localparam int PAL_W = 6;
  localparam int DEPTH = 1 << CH_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_go = 0, upd_global = 0, upd_bypass = 0, upd_wr = 0;
  logic [CH_W-1:0] upd_start = '0;
  logic [CH_W:0] upd_len = '0;
  logic [2*CH_W-1:0] upd_r = '0, upd_g = '0, upd_b = '0;
  logic px_valid = 0, px_palette = 0;
  logic [PAL_W-1:0] px_index = '0;
  logic [CH_W-1:0] px_r = '0, px_g = '0, px_b = '0;
  logic out_valid;
  logic [CH_W-1:0] out_r, out_g, out_b;

  int checks = 0, fails = 0;
  logic [CH_W-1:0] wm [3][DEPTH];
  logic [CH_W-1:0] sm [3][DEPTH];
  int m_cursor = 0, m_left = 0;
  bit m_glob = 0, m_byp = 0;

  always #4 clk = ~clk;

  rgb_lut_chain #(.CH_W(CH_W), .PAL_W(PAL_W)) uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(bit glob, int start, int len, bit byp);
    @(negedge clk);
    upd_go = 1; upd_global = glob; upd_start = CH_W'(start);
    upd_len = (CH_W+1)'(len); upd_bypass = byp;
    @(negedge clk);
    upd_go = 0;
    m_cursor = start; m_left = len; m_glob = glob;
    if (!glob) m_byp = byp;
  endtask

  function automatic void model_beat(logic [2*CH_W-1:0] r, logic [2*CH_W-1:0] g, logic [2*CH_W-1:0] b);
    if (m_left == 0) return;
    if (m_cursor < DEPTH) begin
      if (m_glob) begin
        sm[0][m_cursor] = r[15:8]; sm[1][m_cursor] = g[15:8]; sm[2][m_cursor] = b[15:8];
      end else begin
        wm[0][m_cursor] = r[15:8]; wm[1][m_cursor] = g[15:8]; wm[2][m_cursor] = b[15:8];
      end
    end
    m_cursor++; m_left--;
  endfunction

  task automatic beat(logic [2*CH_W-1:0] r, logic [2*CH_W-1:0] g, logic [2*CH_W-1:0] b);
    upd_wr = 1; upd_r = r; upd_g = g; upd_b = b;
    @(negedge clk);
    upd_wr = 0;
    model_beat(r, g, b);
  endtask

  function automatic logic [15:0] dup(logic [7:0] v);
    return {v, v};
  endfunction

  task automatic load_all(bit glob);
    do_start(glob, 0, DEPTH, 0);
    for (int i = 0; i < DEPTH; i++) begin
      if (glob) beat(dup(8'(i + 7)), dup(8'(i ^ 8'hA5)), dup(8'(255 - i)));
      else      beat(dup(8'(i ^ 8'h3C)), dup(8'(i * 3)), dup(8'(i + 100)));
    end
  endtask

  function automatic int expect_ch(int c, bit pal, int idx, int ch);
    int s1 = pal ? wm[c][idx] : wm[c][ch];
    return m_byp ? s1 : sm[c][s1];
  endfunction

  task automatic px_check(string req, bit pal, int idx, int r, int g, int b);
    int er = expect_ch(0, pal, idx, r);
    int eg = expect_ch(1, pal, idx, g);
    int eb = expect_ch(2, pal, idx, b);
    @(negedge clk);
    px_valid = 1; px_palette = pal; px_index = PAL_W'(idx);
    px_r = CH_W'(r); px_g = CH_W'(g); px_b = CH_W'(b);
    @(negedge clk);
    px_valid = 0;
    check({req, " valid one cycle early"}, int'(out_valid), 0);
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " red"}, int'(out_r), er);
    check({req, " green"}, int'(out_g), eg);
    check({req, " blue"}, int'(out_b), eb);
    @(negedge clk);
    check({req, " valid drop"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", int'(out_valid), 0);
    @(negedge clk);
    upd_wr = 1; upd_r = 16'hEEEE;
    @(negedge clk);
    upd_wr = 0;
  endtask

  task automatic t_truecolor();
    px_check("R2 tc a", 0, 0, 0, 0, 0);
    px_check("R2 tc b", 0, 0, 17, 200, 255);
    px_check("R9 tc c", 0, 0, 128, 64, 1);
  endtask

  task automatic t_palette();
    px_check("R3 pal a", 1, 5, 9, 9, 9);
    px_check("R3 pal top", 1, 63, 250, 0, 3);
  endtask

  task automatic t_bypass();
    do_start(0, 0, 0, 1);
    px_check("R4 bypass on", 0, 0, 40, 41, 42);
    px_check("R4 bypass pal", 1, 12, 0, 0, 0);
    do_start(1, 0, 0, 0);
    px_check("R4 shared go keeps flag", 0, 0, 7, 8, 9);
    do_start(0, 0, 0, 0);
    px_check("R4 bypass off", 0, 0, 40, 41, 42);
  endtask

  task automatic t_partial();
    do_start(0, 10, 2, 0);
    beat(16'hA155, 16'hB266, 16'hC377);
    beat(16'h1111, 16'h2222, 16'h3333);
    beat(16'h9999, 16'h9999, 16'h9999);
    px_check("R5 entry 10 upper byte", 0, 0, 10, 10, 10);
    px_check("R5 entry 11", 0, 0, 11, 11, 11);
    px_check("R8 entry 12 untouched", 0, 0, 12, 12, 12);
  endtask

  task automatic t_len_zero();
    do_start(0, 30, 0, 0);
    beat(16'h7777, 16'h7777, 16'h7777);
    px_check("R6 len zero entry 30", 0, 0, 30, 30, 30);
  endtask

  task automatic t_truncate();
    do_start(0, 254, 4, 0);
    beat(16'h0102, 16'h0304, 16'h0506);
    beat(16'h0708, 16'h090A, 16'h0B0C);
    beat(16'hDEAD, 16'hDEAD, 16'hDEAD);
    beat(16'hBEEF, 16'hBEEF, 16'hBEEF);
    px_check("R7 entry 254", 0, 0, 254, 254, 254);
    px_check("R7 entry 255", 0, 0, 255, 255, 255);
    px_check("R7 no wrap entry 0", 0, 0, 0, 0, 0);
    px_check("R7 no wrap entry 1", 0, 0, 1, 1, 1);
  endtask

  task automatic t_collision();
    int er, eg, eb;
    do_start(0, 5, 1, 0);
    er = expect_ch(0, 0, 0, 5); eg = expect_ch(1, 0, 0, 5); eb = expect_ch(2, 0, 0, 5);
    upd_wr = 1; upd_r = 16'h4242; upd_g = 16'h4343; upd_b = 16'h4444;
    px_valid = 1; px_palette = 0; px_r = 5; px_g = 5; px_b = 5;
    @(negedge clk);
    upd_wr = 0; px_valid = 0;
    model_beat(16'h4242, 16'h4343, 16'h4444);
    @(negedge clk);
    check("R10 collision valid", int'(out_valid), 1);
    check("R10 collision red old", int'(out_r), er);
    check("R10 collision green old", int'(out_g), eg);
    check("R10 collision blue old", int'(out_b), eb);
    px_check("R10 after collision new", 0, 0, 5, 5, 5);
  endtask

  task automatic t_shared_update();
    do_start(1, 100, 1, 0);
    beat(16'h0F0F, 16'hF0F0, 16'h5A5A);
    px_check("R5 shared entry", 0, 0, 100 ^ 8'h3C, 100 / 3 + 0, 0);
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    load_all(1);
    load_all(0);
    t_truecolor();
    t_palette();
    t_bypass();
    t_partial();
    t_len_zero();
    t_truncate();
    t_collision();
    t_shared_update();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule